// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the slave end of a four-wire serial port through which an external host reads and writes a bank of 8-bit configuration registers. The host supplies the serial clock, an active-low select, a read/write select and one data line. The data line is split here into an input, an output and an output enable, and the pad combines them outside this block. Every transfer sends an address byte and then a data byte, most significant bit first. The host changes the data line while the serial clock is low, and the port samples it on the rising edge.

A write sends its data byte from the host. When the sixteenth bit arrives, the port hands the write to the master clock domain through a toggle that passes two synchronising flops, and the register bank is updated in that domain. A read turns the line around after the address byte, and the port then shifts out the addressed register. Registers chosen by a mask parameter are read-only. Their read value comes from a status input, and writes to them are dropped. Raising the select clears the serial state machine asynchronously. A transfer cut short in this way leaves every register unchanged.

Top module: `sercfg_port`

## Requirements
- R1: A write frame is eight address bits followed by eight data bits, both most significant bit first and sampled on rising serial clock edges. It sets the register whose index is address bits [6:2] to the data byte.
- R2: Address bits 7, 1 and 0 have no effect. For example, addresses 0x14, 0x17 and 0x94 all select register 5.
- R3: With the read select high (1 = read, 0 = write), the port returns the addressed register most significant bit first. Bit 7 is valid before the ninth rising edge, and each following bit is valid before the next rising edge.
- R4: The output enable stays low during the address byte and for the whole of any write. On a read it asserts after the eighth rising edge. It drops as soon as the select goes high.
- R5: If the select rises before the sixteenth rising edge, no register changes.
- R6: Registers whose bit in RO_MASK is set (by default indices 0 and 31) ignore writes. A read of one of them returns the matching byte of the status input.
- R7: A completed write appears on the register outputs no earlier than 2 and no later than 4 master clock cycles after the sixteenth rising edge. No register output changes at any other time.
- R8: After master reset, all register outputs are zero and the output enable is low.
- R9: Serial clock edges after the sixteenth in one select window are ignored. A write is applied once with its data byte, and a read keeps the output enable high until the select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| mrst_n | input | 1 | Asynchronous active-low master reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select; high clears the serial state machine |
| rd_wrn | input | 1 | 1 = read transfer, 0 = write transfer |
| sd_i | input | 1 | Data line as seen by the port |
| sd_o | output | 1 | Data line value driven on reads |
| sd_oe | output | 1 | Enable for the data line driver |
| stat_i | input | NREG*DW | Read values of the read-only registers, register i at bits [i*DW +: DW] |
| cfg_q | output | NREG*DW | Register bank contents in the master clock domain |

## Verification
The assertions assume that rd_wrn holds its value for the whole time the select is low. They also assume that the serial clock runs at no more than a quarter of the master clock rate, so that the synchronised toggle cannot be missed. Finally, they assume that the captured write address and data stay stable until the bank has used them. The stimulus generates the serial clock from the master clock with a period of four master cycles and places its edges midway between master clock edges. It sets rd_wrn before the select falls, and it leaves several idle master cycles between transfers.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
  localparam int unsigned DW_DEF   = 8;
  localparam int unsigned NREG_DEF = 32;
  localparam int unsigned IDX_LO   = 2;

  typedef struct packed {
    logic rd;
    logic oe;
  } xfer_mode_t;
endpackage

// File: rtl/sercfg_rst_sync.sv
module sercfg_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stg_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stg_q  <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      stg_q  <= 1'b1;
      srst_n <= stg_q;
    end
  end
endmodule

// File: rtl/sercfg_shift.sv
module sercfg_shift
  import sercfg_pkg::*;
#(
  parameter int unsigned DW   = DW_DEF,
  parameter int unsigned NREG = NREG_DEF,
  localparam int unsigned IW  = $clog2(NREG),
  localparam int unsigned FRM = 2 * DW,
  localparam int unsigned CW  = $clog2(FRM + 1)
) (
  input  logic                 sclk,
  input  logic                 cs_n,
  input  logic                 mrst_n,
  input  logic                 rd_wrn,
  input  logic                 sd_i,
  input  logic [NREG*DW-1:0]   rd_vec,
  output logic                 sd_o,
  output logic                 sd_oe,
  output logic                 wr_tgl,
  output logic [IW-1:0]        wr_idx,
  output logic [DW-1:0]        wr_dat
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-2:0] sh_q, sh_d;
  logic [DW-1:0] rsh_q, rsh_d;
  logic [IW-1:0] idx_q, idx_d;
  xfer_mode_t    md_q, md_d;
  logic          run, addr_done, wr_fire, rd_shift;

  assign run       = (cnt_q < CW'(FRM));
  assign addr_done = (cnt_q == CW'(DW - 1));
  assign wr_fire   = (cnt_q == CW'(FRM - 1)) && !md_q.rd;
  assign rd_shift  = md_q.oe && (cnt_q >= CW'(DW)) && (cnt_q < CW'(FRM - 1));

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    rsh_d = rsh_q;
    idx_d = idx_q;
    md_d  = md_q;
    if (run) begin
      cnt_d = cnt_q + CW'(1);
      sh_d  = {sh_q[DW-3:0], sd_i};
    end
    if (addr_done) begin
      idx_d   = sh_q[IDX_LO+IW-2:IDX_LO-1];
      md_d.rd = rd_wrn;
      md_d.oe = rd_wrn;
      rsh_d   = rd_vec[sh_q[IDX_LO+IW-2:IDX_LO-1]*DW +: DW];
    end else if (rd_shift) begin
      rsh_d = {rsh_q[DW-2:0], 1'b0};
    end
  end

  always_ff @(posedge sclk or posedge cs_n) begin
    if (cs_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
      rsh_q <= '0;
      idx_q <= '0;
      md_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      rsh_q <= rsh_d;
      idx_q <= idx_d;
      md_q  <= md_d;
    end
  end

  // write hand-off registers survive cs_n so the bank can still read them
  always_ff @(posedge sclk or negedge mrst_n) begin
    if (!mrst_n) begin
      wr_tgl <= 1'b0;
      wr_idx <= '0;
      wr_dat <= '0;
    end else if (wr_fire) begin
      wr_tgl <= !wr_tgl;
      wr_idx <= idx_q;
      wr_dat <= {sh_q, sd_i};
    end
  end

  assign sd_o  = rsh_q[DW-1];
  assign sd_oe = md_q.oe;
endmodule

// File: rtl/sercfg_regbank.sv
module sercfg_regbank
  import sercfg_pkg::*;
#(
  parameter int unsigned DW      = DW_DEF,
  parameter int unsigned NREG    = NREG_DEF,
  parameter logic [NREG-1:0] RO_MASK = '0,
  localparam int unsigned IW     = $clog2(NREG)
) (
  input  logic               mclk,
  input  logic               srst_n,
  input  logic               wr_tgl,
  input  logic [IW-1:0]      wr_idx,
  input  logic [DW-1:0]      wr_dat,
  input  logic [NREG*DW-1:0] stat_i,
  output logic [NREG*DW-1:0] cfg_q,
  output logic [NREG*DW-1:0] rd_vec,
  output logic               wr_pls
);
  logic [2:0] sy_q;
  logic       wr_en;

  always_ff @(posedge mclk or negedge srst_n) begin
    if (!srst_n) sy_q <= '0;
    else         sy_q <= {sy_q[1:0], wr_tgl};
  end

  assign wr_pls = sy_q[1] ^ sy_q[2];
  assign wr_en  = wr_pls && !RO_MASK[wr_idx];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic          hit;
    logic [DW-1:0] nxt;
    assign hit = wr_en && (wr_idx == IW'(g));
    always_comb begin
      nxt = cfg_q[g*DW +: DW];
      if (hit) nxt = wr_dat;
    end
    always_ff @(posedge mclk or negedge srst_n) begin
      if (!srst_n) cfg_q[g*DW +: DW] <= '0;
      else         cfg_q[g*DW +: DW] <= nxt;
    end
    assign rd_vec[g*DW +: DW] = RO_MASK[g] ? stat_i[g*DW +: DW] : cfg_q[g*DW +: DW];
  end
endmodule

// File: rtl/sercfg_port.sv
module sercfg_port
  import sercfg_pkg::*;
#(
  parameter int unsigned DW      = DW_DEF,
  parameter int unsigned NREG    = NREG_DEF,
  parameter logic [NREG-1:0] RO_MASK = 32'h8000_0001,
  localparam int unsigned IW     = $clog2(NREG)
) (
  input  logic               mclk,
  input  logic               mrst_n,
  input  logic               sclk,
  input  logic               cs_n,
  input  logic               rd_wrn,
  input  logic               sd_i,
  output logic               sd_o,
  output logic               sd_oe,
  input  logic [NREG*DW-1:0] stat_i,
  output logic [NREG*DW-1:0] cfg_q
);
  logic               srst_n;
  logic               wr_tgl, wr_pls;
  logic [IW-1:0]      wr_idx;
  logic [DW-1:0]      wr_dat;
  logic [NREG*DW-1:0] rd_vec;

  sercfg_rst_sync i_rst (.clk(mclk), .arst_n(mrst_n), .srst_n(srst_n));

  sercfg_shift #(.DW(DW), .NREG(NREG)) i_shift (
    .sclk(sclk), .cs_n(cs_n), .mrst_n(mrst_n), .rd_wrn(rd_wrn), .sd_i(sd_i),
    .rd_vec(rd_vec), .sd_o(sd_o), .sd_oe(sd_oe), .wr_tgl(wr_tgl),
    .wr_idx(wr_idx), .wr_dat(wr_dat)
  );

  sercfg_regbank #(.DW(DW), .NREG(NREG), .RO_MASK(RO_MASK)) i_bank (
    .mclk(mclk), .srst_n(srst_n), .wr_tgl(wr_tgl), .wr_idx(wr_idx),
    .wr_dat(wr_dat), .stat_i(stat_i), .cfg_q(cfg_q), .rd_vec(rd_vec),
    .wr_pls(wr_pls)
  );
endmodule

// File: rtl/sercfg_port_chk.sv
module sercfg_port_chk #(
  parameter int unsigned DW   = 8,
  parameter int unsigned NREG = 32,
  parameter logic [NREG-1:0] RO_MASK = '0,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input logic               mclk,
  input logic               mrst_n,
  input logic               cs_n,
  input logic               rd_wrn,
  input logic               sd_oe,
  input logic               wr_pls,
  input logic [IW-1:0]      wr_idx,
  input logic [NREG*DW-1:0] cfg_q
);
  p_oe_dropped_r4: assert property (@(posedge mclk) disable iff (!mrst_n)
    cs_n |-> !sd_oe);

  p_oe_on_read_only_r4: assert property (@(posedge mclk) disable iff (!mrst_n)
    sd_oe |-> rd_wrn);

  p_ro_write_dropped_r6: assert property (@(posedge mclk) disable iff (!mrst_n)
    (wr_pls && RO_MASK[wr_idx]) |=> $stable(cfg_q));

  p_change_after_strobe_r7: assert property (@(posedge mclk) disable iff (!mrst_n)
    !$stable(cfg_q) |-> $past(wr_pls));

  p_single_strobe_r9: assert property (@(posedge mclk) disable iff (!mrst_n)
    wr_pls |=> !wr_pls);
endmodule

bind sercfg_port sercfg_port_chk #(.DW(DW), .NREG(NREG), .RO_MASK(RO_MASK)) i_chk (
  .mclk(mclk), .mrst_n(mrst_n), .cs_n(cs_n), .rd_wrn(rd_wrn), .sd_oe(sd_oe),
  .wr_pls(wr_pls), .wr_idx(wr_idx), .cfg_q(cfg_q)
);

// File: tb/test_sercfg_port.sv
module test_sercfg_port;
  localparam int DW = 8;
  localparam int NREG = 32;
  localparam logic [NREG-1:0] ROM = 32'h8000_0001;
  localparam time TCK = 10ns;
  localparam int WDOG = 150000;

  logic mclk, mrst_n, sclk, cs_n, rd_wrn, sd_i, sd_o, sd_oe;
  logic [NREG*DW-1:0] stat_i, cfg_q;

  int checks = 0, errors = 0;
  bit settled = 0, done = 0;
  logic [DW-1:0] model [NREG];

  sercfg_port #(.DW(DW), .NREG(NREG), .RO_MASK(ROM)) i_sercfg_port (.*);

  initial mclk = 1'b0;
  always #(TCK/2) mclk = ~mclk;

  for (genvar g = 0; g < NREG; g++) begin : g_st
    assign stat_i[g*DW +: DW] = 8'hA0 + 8'(g);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // reference model compared on every master clock while no write is in flight
  always @(negedge mclk) begin
    if (settled) begin
      for (int i = 0; i < NREG; i++)
        chk(cfg_q[i*DW +: DW] === model[i], "R1/R7 bank vs model", cfg_q[i*DW +: DW], model[i]);
    end
  end

  function automatic int idx_of(input logic [7:0] a);
    return int'(a[6:2]);
  endfunction

  // nbits < 16 aborts, > 16 adds trailing clocks
  task automatic xfer(input bit rd, input logic [7:0] addr, input logic [7:0] wd,
                      input int nbits, input bit meas, output logic [7:0] rdat);
    logic bitv;
    int idx;
    idx = idx_of(addr);
    rdat = 'x;
    @(negedge mclk);
    settled = 0;
    rd_wrn = rd;
    #(TCK);
    cs_n = 1'b0;
    #(TCK*2);
    for (int i = 0; i < nbits; i++) begin
      bitv = (i < 8) ? addr[7-i] : (i < 16) ? wd[15-i] : ~wd[0];
      sd_i = bitv;
      #(TCK*2 - 1ns);
      if (i < 8 || !rd) chk(sd_oe === 1'b0, "R4 oe low", sd_oe, 0);
      else chk(sd_oe === 1'b1, (i < 16) ? "R4 oe high on read" : "R9 oe held", sd_oe, 1);
      if (rd && i >= 8 && i < 16) rdat[15-i] = sd_o;
      #1ns;
      sclk = 1'b1;
      if (i == 15 && !rd && !ROM[idx]) model[idx] = wd;
      if (i == 15 && !rd && meas) begin
        int n = 0;
        while (n < 8 && cfg_q[idx*DW +: DW] !== wd) begin
          @(negedge mclk);
          n++;
        end
        chk(n >= 2 && n <= 4, "R7 write latency", n, 3);
        #(TCK/2);
      end
      #(TCK*2);
      sclk = 1'b0;
    end
    #(TCK*2);
    cs_n = 1'b1;
    #1ns;
    chk(sd_oe === 1'b0, "R4 oe drops with cs_n", sd_oe, 0);
    repeat (8) @(negedge mclk);
    settled = 1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] r;
    xfer(1'b0, a, d, 16, 1'b0, r);
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
    logic [7:0] r;
    xfer(1'b1, a, 8'h00, 16, 1'b0, r);
    chk(r === exp, req, r, exp);
  endtask

  initial begin
    logic [7:0] r;
    for (int i = 0; i < NREG; i++) model[i] = '0;
    mrst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; rd_wrn = 1'b0; sd_i = 1'b0;
    repeat (4) @(negedge mclk);
    mrst_n = 1'b1;
    repeat (4) @(negedge mclk);
    chk(cfg_q === '0, "R8 bank zero after reset", 0, 0);
    chk(sd_oe === 1'b0, "R8 oe low after reset", sd_oe, 0);
    settled = 1;

    // R1 basic write with latency, R3 readback
    xfer(1'b0, 8'h14, 8'hA5, 16, 1'b1, r);
    rd_chk(8'h14, 8'hA5, "R3 read reg5");
    // R2 low and top address bits ignored
    wr(8'h17, 8'h3C);
    rd_chk(8'h14, 8'h3C, "R2 0x17 aliases reg5");
    wr(8'h94, 8'h5A);
    rd_chk(8'h17, 8'h5A, "R2 0x94 aliases reg5");
    // R1 several registers and patterns
    for (int i = 1; i < 31; i += 7) begin
      xfer(1'b0, 8'(i << 2), 8'(8'h11 * i + 3), 16, 1'b1, r);
      rd_chk(8'(i << 2), 8'(8'h11 * i + 3), "R1 write then read");
    end
    // R6 read-only registers
    wr(8'h00, 8'hFF);
    wr(8'h7C, 8'h77);
    chk(cfg_q[0 +: 8] === 8'h00, "R6 reg0 write ignored", cfg_q[0 +: 8], 0);
    rd_chk(8'h00, 8'hA0, "R6 reg0 reads status");
    rd_chk(8'h7F, 8'hBF, "R6 reg31 reads status");
    // R5 aborted transfers
    wr(8'h18, 8'h42);
    xfer(1'b0, 8'h18, 8'hC3, 12, 1'b0, r);
    xfer(1'b0, 8'h18, 8'hC3, 15, 1'b0, r);
    rd_chk(8'h18, 8'h42, "R5 aborted write left reg6");
    // R9 trailing clocks
    xfer(1'b0, 8'h20, 8'h96, 21, 1'b0, r);
    rd_chk(8'h20, 8'h96, "R9 trailing clocks ignored on write");
    xfer(1'b1, 8'h20, 8'h00, 20, 1'b0, r);
    chk(r === 8'h96, "R9 read with trailing clocks", r, 8'h96);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge mclk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule